// File: doc/BRIEF.md
# Multi-Semantics Float to Integer Converter

This unit turns a binary64 operand into a signed or unsigned integer of 32 or 64 bits, ready to be written to a general-purpose register. Single-precision sources reach it already widened to double form. A 3-bit mode picks two things together. The first is where the rounding direction comes from: the floating-point status rounding field, or forced truncation. The second is how NaN and out-of-range inputs behave. Three behaviours are available. Two clamp to the integer limits and differ only in what NaN gives: the integer minimum in one, zero in the other. The third wraps modulo 2^N and turns NaN and both infinities into zero.

The datapath is combinational and ends in one output register. A conversion presented with `in_valid` in one cycle appears on the outputs one cycle later with `out_valid` set. A new conversion can start every cycle. Exception and status flag updates are not part of this unit.

Top module: `fcvt_int_unit`

## Requirements
- R1: `in_mode[2:1]` selects the semantics: 00 clamps with NaN to minimum, 01 clamps with NaN to zero, 10 wraps. `in_mode[0]`=1 forces truncation. The modes 110 and 111 set `out_illegal` and give a result of zero.
- R2: When `in_mode[0]`=0, rounding follows `in_rmode`: 00 nearest with ties to even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: When `in_mode[0]`=1, truncation is used whatever the value of `in_rmode`.
- R4: With semantics 00, a NaN operand gives the integer minimum: 0 when unsigned, -2^(N-1) when signed.
- R5: With semantics 01, a NaN operand gives 0.
- R6: With both clamping semantics, an operand that is at or above the integer maximum before rounding gives the maximum. An operand at or below the minimum gives the minimum. Infinities and negative operands with an unsigned target follow the same rule.
- R7: With wrapping semantics, NaN and either infinity give 0. Any other operand is rounded, reduced modulo 2^N, and its low N bits are read back with the target signedness.
- R8: When `in_wide`=0 the target is 32 bits. The 64-bit result is sign-extended from bit 31 when `in_signed`=1 and zero-extended otherwise. When `in_wide`=1 the target is 64 bits.
- R9: `out_valid` rises exactly one cycle after `in_valid` and is low when `in_valid` was low. Reset clears `out_valid`, `out_result` and `out_illegal`.
- R10: With wrapping semantics, a finite operand of magnitude 2^64 or more keeps the integer bits below 2^64. It reduces to 0 only once its lowest significand bit weighs 2^64 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and controls are presented this cycle |
| in_operand | input | 64 | binary64 source operand |
| in_mode | input | 3 | Rounding source and semantics select |
| in_rmode | input | 2 | Status rounding field |
| in_wide | input | 1 | 1: 64-bit target, 0: 32-bit target |
| in_signed | input | 1 | 1: signed target |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 64 | Integer result |
| out_illegal | output | 1 | Mode was 110 or 111 |

## Verification
Small fractions are driven with ties, with values just above ties and with values below one half. This separates the four rounding directions from one another and from forced truncation. NaN, both infinities and values exactly at the signed and unsigned limits are run through every semantics, so the NaN result and the clamp boundaries are shown to depend on the mode and target. Values beyond 2^32 and 2^64, together with negative operands on unsigned targets, exercise the wrap path against the clamp path. One value of 2^64 plus low-order bits shows that wrapping keeps those bits and does not flush to zero.

// File: rtl/fcvt_pkg.sv
`timescale 1ns/1ps
package fcvt_pkg;
    parameter int EXP_W  = 11;
    parameter int FRAC_W = 52;
    parameter int MANT_W = FRAC_W + 1;
    parameter int BIAS   = (1 << (EXP_W - 1)) - 1;
    parameter int INT_W  = 64;
    parameter int HALF_W = INT_W / 2;
    parameter int OP_W   = 1 + EXP_W + FRAC_W;
    // fixed-point field: INT_W fraction bits, 2*INT_W integer bits
    parameter int FIX_W  = 3 * INT_W;

    typedef enum logic [1:0] {
        SEM_SAT_MIN  = 2'b00,
        SEM_SAT_ZERO = 2'b01,
        SEM_WRAP     = 2'b10,
        SEM_BAD      = 2'b11
    } sem_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_ZERO = 2'b01,
        RND_UP   = 2'b10,
        RND_DOWN = 2'b11
    } rnd_e;

    typedef struct packed {
        logic              sign;
        logic              is_nan;
        logic              is_inf;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
    } fp_fields_t;

    typedef struct packed {
        sem_e sem;
        rnd_e rnd;
        logic illegal;
    } ctl_t;

    typedef struct packed {
        logic [INT_W-1:0] int_part;   // truncated magnitude, low INT_W bits
        logic             huge;       // truncated magnitude >= 2^INT_W
        logic [INT_W-1:0] signed_val; // rounded, signed, modulo 2^INT_W
    } aligned_t;

    function automatic logic [INT_W-1:0] int_max(input logic wide, input logic sgn);
        logic [INT_W-1:0] v;
        if (wide) v = sgn ? {1'b0, {(INT_W-1){1'b1}}} : {INT_W{1'b1}};
        else      v = sgn ? {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}}
                          : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        return v;
    endfunction

    function automatic logic [INT_W-1:0] int_min(input logic wide, input logic sgn);
        logic [INT_W-1:0] v;
        if (!sgn)     v = '0;
        else if (wide) v = {1'b1, {(INT_W-1){1'b0}}};
        else           v = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
        return v;
    endfunction

    // magnitude of the most negative value of the target (signed only)
    function automatic logic [INT_W-1:0] neg_limit(input logic wide);
        return wide ? {1'b1, {(INT_W-1){1'b0}}}
                    : {{HALF_W{1'b0}}, 1'b1, {(HALF_W-1){1'b0}}};
    endfunction

    function automatic logic [INT_W-1:0] fit_width(input logic [INT_W-1:0] v,
                                                    input logic wide, input logic sgn);
        logic [INT_W-1:0] r;
        if (wide)     r = v;
        else if (sgn) r = {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
        else          r = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
        return r;
    endfunction
endpackage

// File: rtl/fcvt_classify.sv
`timescale 1ns/1ps
module fcvt_classify
    import fcvt_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  logic [2:0]      mode,
    input  logic [1:0]      rmode,
    output fp_fields_t      fields,
    output ctl_t            ctl
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;

    always_comb begin
        exp_f   = operand[OP_W-2 -: EXP_W];
        frac_f  = operand[FRAC_W-1:0];
        exp_max = &exp_f;

        fields.sign   = operand[OP_W-1];
        fields.exp    = exp_f;
        fields.mant   = {(exp_f != '0), frac_f};
        fields.is_nan = exp_max && (frac_f != '0);
        fields.is_inf = exp_max && (frac_f == '0);

        ctl.sem     = sem_e'(mode[2:1]);
        ctl.illegal = (mode[2:1] == 2'b11);
        ctl.rnd     = mode[0] ? RND_ZERO : rnd_e'(rmode);
    end
endmodule

// File: rtl/fcvt_align_round.sv
`timescale 1ns/1ps
module fcvt_align_round
    import fcvt_pkg::*;
(
    input  fp_fields_t fields,
    input  rnd_e       rnd,
    output aligned_t   aligned
);
    // below this exponent the magnitude is under one half
    localparam logic [EXP_W-1:0] LO_E   = EXP_W'(BIAS - 1);
    // from this exponent the lowest significand bit weighs 2^INT_W or more
    localparam logic [EXP_W-1:0] ZERO_E = EXP_W'(BIAS + FRAC_W + INT_W);
    // exponent that puts the significand LSB at fraction bit 0 of the field
    localparam logic [EXP_W-1:0] SH_OFF = EXP_W'(BIAS + FRAC_W - INT_W);

    logic [FIX_W-1:0] fixed;
    logic [EXP_W-1:0] sh;
    logic [INT_W-1:0] int_part;
    logic             huge;
    logic             guard;
    logic             sticky;
    logic             inc;
    logic [INT_W-1:0] rounded;

    always_comb begin
        sh       = fields.exp - SH_OFF;
        fixed    = '0;
        int_part = '0;
        huge     = 1'b0;
        guard    = 1'b0;
        sticky   = 1'b0;
        if (fields.exp < LO_E) begin
            sticky = (fields.mant != '0);
        end else if (fields.exp >= ZERO_E) begin
            huge = 1'b1;
        end else begin
            fixed    = FIX_W'(fields.mant) << sh;
            int_part = fixed[2*INT_W-1:INT_W];
            huge     = (fixed[FIX_W-1:2*INT_W] != '0);
            guard    = fixed[INT_W-1];
            sticky   = (fixed[INT_W-2:0] != '0);
        end

        unique case (rnd)
            RND_NEAR: inc = guard & (sticky | int_part[0]);
            RND_ZERO: inc = 1'b0;
            RND_UP:   inc = ~fields.sign & (guard | sticky);
            RND_DOWN: inc =  fields.sign & (guard | sticky);
            default:  inc = 1'b0;
        endcase

        // increment on the magnitude, then negate for negative inputs
        rounded = int_part + INT_W'(inc);

        aligned.int_part   = int_part;
        aligned.huge       = huge;
        aligned.signed_val = fields.sign ? (~rounded + 1'b1) : rounded;
    end
endmodule

// File: rtl/fcvt_resolve.sv
`timescale 1ns/1ps
module fcvt_resolve
    import fcvt_pkg::*;
(
    input  fp_fields_t       fields,
    input  ctl_t             ctl,
    input  aligned_t         aligned,
    input  logic             wide,
    input  logic             sgn,
    output logic [INT_W-1:0] result
);
    logic [INT_W-1:0] lim_hi;
    logic [INT_W-1:0] lim_lo;
    logic [INT_W-1:0] in_range;
    logic             clamp_hi;
    logic             clamp_lo;
    logic [INT_W-1:0] sat_val;

    always_comb begin
        lim_hi   = int_max(wide, sgn);
        lim_lo   = int_min(wide, sgn);
        in_range = fit_width(aligned.signed_val, wide, sgn);

        // decisions on the truncated magnitude, i.e. before rounding
        clamp_hi = aligned.huge || (aligned.int_part >= lim_hi);
        clamp_lo = !sgn || aligned.huge || (aligned.int_part >= neg_limit(wide));

        if (fields.is_nan)
            sat_val = (ctl.sem == SEM_SAT_MIN) ? lim_lo : '0;
        else if (fields.sign)
            sat_val = clamp_lo ? lim_lo : in_range;
        else
            sat_val = clamp_hi ? lim_hi : in_range;

        unique case (ctl.sem)
            SEM_SAT_MIN, SEM_SAT_ZERO: result = sat_val;
            SEM_WRAP: result = (fields.is_nan || fields.is_inf) ? '0 : in_range;
            default:  result = '0;
        endcase
    end
endmodule

// File: rtl/fcvt_int_unit.sv
`timescale 1ns/1ps
module fcvt_int_unit
    import fcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_operand,
    input  logic [2:0]        in_mode,
    input  logic [1:0]        in_rmode,
    input  logic              in_wide,
    input  logic              in_signed,
    output logic              out_valid,
    output logic [INT_W-1:0]  out_result,
    output logic              out_illegal
);
    fp_fields_t       fields;
    ctl_t             ctl;
    aligned_t         aligned;
    logic [INT_W-1:0] conv;

    fcvt_classify u_classify (
        .operand (in_operand),
        .mode    (in_mode),
        .rmode   (in_rmode),
        .fields  (fields),
        .ctl     (ctl)
    );

    fcvt_align_round u_align (
        .fields  (fields),
        .rnd     (ctl.rnd),
        .aligned (aligned)
    );

    fcvt_resolve u_resolve (
        .fields  (fields),
        .ctl     (ctl),
        .aligned (aligned),
        .wide    (in_wide),
        .sgn     (in_signed),
        .result  (conv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_illegal <= ctl.illegal;
                out_result  <= ctl.illegal ? '0 : conv;
            end
        end
    end
endmodule

// File: rtl/fcvt_int_unit_checker.sv
`timescale 1ns/1ps
module fcvt_int_unit_checker
    import fcvt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  in_operand,
    input logic [2:0]       in_mode,
    input logic             in_wide,
    input logic             in_signed,
    input logic             out_valid,
    input logic [INT_W-1:0] out_result,
    input logic             out_illegal
);
    logic op_nan;
    logic op_inf;
    assign op_nan = (&in_operand[OP_W-2 -: EXP_W]) && (in_operand[FRAC_W-1:0] != '0);
    assign op_inf = (&in_operand[OP_W-2 -: EXP_W]) && (in_operand[FRAC_W-1:0] == '0);

    p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_illegal_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] == 2'b11) |=> (out_illegal && out_result == '0));

    p_legal_flag_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] != 2'b11) |=> !out_illegal);

    p_nan_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] == 2'b01 && op_nan) |=> (out_result == '0));

    p_wrap_special_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[2:1] == 2'b10 && (op_nan || op_inf)) |=> (out_result == '0));

    p_sext_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && in_signed) |=>
            (out_result[INT_W-1:HALF_W] == {HALF_W{out_result[HALF_W-1]}}));

    p_zext_narrow_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_wide && !in_signed) |=> (out_result[INT_W-1:HALF_W] == '0));
endmodule

bind fcvt_int_unit fcvt_int_unit_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_operand  (in_operand),
    .in_mode     (in_mode),
    .in_wide     (in_wide),
    .in_signed   (in_signed),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_illegal (out_illegal)
);

// File: tb/fcvt_int_unit_bench.sv
`timescale 1ns/1ps
module fcvt_int_unit_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_operand;
    logic [2:0]  in_mode;
    logic [1:0]  in_rmode;
    logic        in_wide;
    logic        in_signed;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_illegal;

    int n_run  = 0;
    int n_fail = 0;

    logic [63:0] q_res[$];
    logic        q_ill[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    fcvt_int_unit u_fcvt_int_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_mode(in_mode), .in_rmode(in_rmode), .in_wide(in_wide),
        .in_signed(in_signed), .out_valid(out_valid), .out_result(out_result),
        .out_illegal(out_illegal)
    );

    localparam logic [63:0] F_1P0   = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] F_N1P0  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] F_1P5   = 64'h3FF8_0000_0000_0000;
    localparam logic [63:0] F_2P5   = 64'h4004_0000_0000_0000;
    localparam logic [63:0] F_N2P5  = 64'hC004_0000_0000_0000;
    localparam logic [63:0] F_2P75  = 64'h4006_0000_0000_0000;
    localparam logic [63:0] F_NP5   = 64'hBFE0_0000_0000_0000;
    localparam logic [63:0] F_P25   = 64'h3FD0_0000_0000_0000;
    localparam logic [63:0] F_NAN   = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] F_PINF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] F_NINF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] F_2E31  = 64'h41E0_0000_0000_0000;
    localparam logic [63:0] F_M2E31 = 64'hC1E0_0000_0000_0000;
    localparam logic [63:0] F_2E31M = 64'h41DF_FFFF_FFC0_0000; // 2^31-1
    localparam logic [63:0] F_2E32P5 = 64'h41F0_0000_0050_0000; // 2^32+5
    localparam logic [63:0] F_2E63  = 64'h43E0_0000_0000_0000;
    localparam logic [63:0] F_2E64  = 64'h43F0_0000_0000_0000;
    localparam logic [63:0] F_2E64L = 64'h43F0_0000_0000_0001; // 2^64+2^12
    localparam logic [63:0] F_2E116 = 64'h4730_0000_0000_0000;

    localparam logic [63:0] MIN_S32 = 64'hFFFF_FFFF_8000_0000;
    localparam logic [63:0] MAX_S32 = 64'h0000_0000_7FFF_FFFF;
    localparam logic [63:0] MAX_U32 = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] MAX_S64 = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MIN_S64 = 64'h8000_0000_0000_0000;

    task automatic send(input logic [63:0] op, input logic [2:0] md, input logic [1:0] rm,
                        input logic w, input logic s, input logic [63:0] exp_res,
                        input logic exp_ill, input string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        in_operand = op;
        in_mode    = md;
        in_rmode   = rm;
        in_wide    = w;
        in_signed  = s;
        q_res.push_back(exp_res);
        q_ill.push_back(exp_ill);
        q_tag.push_back(tag);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_run++;
            if (q_res.size() == 0) begin
                n_fail++;
                $display("FAIL R9 unexpected result: actual=%h expected=none", out_result);
            end else begin
                logic [63:0] er;
                logic        ei;
                string       tg;
                er = q_res.pop_front();
                ei = q_ill.pop_front();
                tg = q_tag.pop_front();
                if (out_result !== er || out_illegal !== ei) begin
                    n_fail++;
                    $display("FAIL %s: actual=%h/%b expected=%h/%b", tg, out_result,
                             out_illegal, er, ei);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual=hang expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_operand = '0; in_mode = '0;
        in_rmode = '0; in_wide = 1'b0; in_signed = 1'b0;
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || out_result !== '0 || out_illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset state: actual=%b/%h/%b expected=0/0/0",
                     out_valid, out_result, out_illegal);
        end
        rst = 1'b0;

        // R2 rounding directions, 64-bit signed, semantics 00
        send(F_2P5,  3'b000, 2'b00, 1, 1, 64'd2, 0, "R2 2.5 nearest-even");
        send(F_1P5,  3'b000, 2'b00, 1, 1, 64'd2, 0, "R2 1.5 nearest-even");
        send(F_2P75, 3'b000, 2'b00, 1, 1, 64'd3, 0, "R2 2.75 nearest");
        send(F_NP5,  3'b000, 2'b00, 1, 1, 64'd0, 0, "R2 -0.5 nearest-even");
        send(F_2P5,  3'b000, 2'b01, 1, 1, 64'd2, 0, "R2 2.5 toward zero");
        send(F_2P5,  3'b000, 2'b10, 1, 1, 64'd3, 0, "R2 2.5 toward +inf");
        send(F_N2P5, 3'b000, 2'b11, 1, 1, 64'hFFFF_FFFF_FFFF_FFFD, 0, "R2 -2.5 toward -inf");
        send(F_N2P5, 3'b000, 2'b10, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R2 -2.5 toward +inf");
        send(F_P25,  3'b010, 2'b10, 1, 1, 64'd1, 0, "R2 0.25 toward +inf");
        // R3 truncation ignores status field
        send(F_2P5,  3'b001, 2'b10, 1, 1, 64'd2, 0, "R3 2.5 trunc over +inf");
        send(F_N2P5, 3'b011, 2'b11, 1, 1, 64'hFFFF_FFFF_FFFF_FFFE, 0, "R3 -2.5 trunc over -inf");
        // R4 / R5 NaN
        send(F_NAN, 3'b000, 2'b00, 0, 1, MIN_S32, 0, "R4 NaN signed32 minimum");
        send(F_NAN, 3'b001, 2'b00, 1, 0, 64'd0,   0, "R4 NaN unsigned64 minimum");
        send(F_NAN, 3'b000, 2'b00, 1, 1, MIN_S64, 0, "R4 NaN signed64 minimum");
        send(F_NAN, 3'b010, 2'b00, 1, 1, 64'd0,   0, "R5 NaN signed64 zero");
        send(F_NAN, 3'b011, 2'b00, 0, 1, 64'd0,   0, "R5 NaN signed32 zero");
        // R6 clamping
        send(F_PINF,   3'b000, 2'b00, 1, 1, MAX_S64, 0, "R6 +inf signed64 max");
        send(F_NINF,   3'b010, 2'b00, 0, 1, MIN_S32, 0, "R6 -inf signed32 min");
        send(F_2E31,   3'b000, 2'b00, 0, 1, MAX_S32, 0, "R6 2^31 signed32 max");
        send(F_2E31M,  3'b001, 2'b00, 0, 1, MAX_S32, 0, "R6 2^31-1 signed32 max");
        send(F_M2E31,  3'b000, 2'b00, 0, 1, MIN_S32, 0, "R6 -2^31 signed32 min");
        send(F_N1P0,   3'b000, 2'b00, 0, 0, 64'd0,   0, "R6 -1 unsigned32 min");
        send(F_2E32P5, 3'b000, 2'b00, 0, 0, MAX_U32, 0, "R6 2^32+5 unsigned32 max");
        send(F_2E63,   3'b000, 2'b00, 1, 1, MAX_S64, 0, "R6 2^63 signed64 max");
        send(F_2E64,   3'b010, 2'b00, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R6 2^64 unsigned64 max");
        // R7 wrapping
        send(F_2E32P5, 3'b101, 2'b00, 0, 0, 64'd5, 0, "R7 2^32+5 wraps to 5");
        send(F_PINF,   3'b100, 2'b00, 1, 1, 64'd0, 0, "R7 +inf wraps to 0");
        send(F_NAN,    3'b101, 2'b00, 0, 0, 64'd0, 0, "R7 NaN wraps to 0");
        send(F_2P5,    3'b100, 2'b10, 0, 0, 64'd3, 0, "R7 2.5 rounded up then wrapped");
        // R8 width extension
        send(F_2E31,   3'b100, 2'b00, 0, 1, MIN_S32, 0, "R8 2^31 wrap signed32 sign-extended");
        send(F_N1P0,   3'b100, 2'b00, 0, 0, MAX_U32, 0, "R8 -1 wrap unsigned32 zero-extended");
        send(F_N1P0,   3'b100, 2'b00, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R8 -1 wrap signed32");
        send(F_1P0,    3'b000, 2'b00, 0, 0, 64'd1, 0, "R8 1.0 unsigned32");
        // R10 large magnitude wrap
        send(F_2E64L,  3'b100, 2'b00, 1, 0, 64'h1000, 0, "R10 2^64+2^12 keeps low bits");
        send(F_2E116,  3'b101, 2'b00, 1, 1, 64'd0,    0, "R10 2^116 reduces to 0");
        // R1 illegal modes
        send(F_2P5,    3'b110, 2'b00, 1, 1, 64'd0, 1, "R1 mode 110 illegal");
        send(F_1P0,    3'b111, 2'b01, 0, 0, 64'd0, 1, "R1 mode 111 illegal");
        send(F_1P0,    3'b010, 2'b00, 1, 1, 64'd1, 0, "R1 legal after illegal");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || q_res.size() != 0) begin
            n_fail++;
            $display("FAIL R9 drain: actual=%b/%0d expected=0/0", out_valid, q_res.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule